// File: doc/BRIEF.md
# Paged DMA Address Generator

This block builds the 32-bit physical bus address for one DMA channel. The address is held in three registers. A 16-bit running address register holds the part that moves with each transfer. An 8-bit page register supplies the middle address bits. An 8-bit upper-page register supplies the top byte. Software loads each register one byte at a time through load strobes that share one data bus. During a transfer, one advance pulse per transfer steps the running address.

The block has two modes. In byte mode the running address counts bytes and sits directly under the page. In word mode it counts 16-bit words, so it is shifted up by one bit. In that mode the lowest page bit plays no part and address bit 0 is always zero.

If the upper page has not been written since the last write to the running address or the page, a carry out of the running address is dropped. The address then wraps inside a 64 KiB window (byte mode) or a 128 KiB window (word mode). Writing the upper page last turns carry on, so the address can run across the whole 32-bit space. A byte-lane enable pair goes with every address.

Top module: `paged_dma_addr_gen`

## Requirements
- R1: In byte mode, bus_addr[15:0] is the running address, bus_addr[23:16] is the page and bus_addr[31:24] is the upper page.
- R2: In word mode, bus_addr[16:1] is the running address, bus_addr[23:17] is page bits 7:1, bus_addr[31:24] is the upper page and bus_addr[0] is 0. Page bit 0 has no effect on the output.
- R3: With extension off, an advance from running address 0xFFFF gives 0x0000 and leaves the page and upper page unchanged.
- R4: A write to the upper page turns extension on. A write to either running-address byte or to the page without an upper-page write in the same cycle turns it off. Extension is off after reset.
- R5: With extension on, an advance from 0xFFFF carries into the page. In byte mode {upper page, page} goes up by one as a 16-bit value. In word mode {upper page, page[7:1]} goes up by one and page bit 0 is kept.
- R6: An advance with no write in the same cycle raises the running address by one unit: one byte in byte mode, one 16-bit word in word mode.
- R7: lane_en is 2'b11 in word mode. In byte mode it is 2'b01 when bus_addr[0] is 0 and 2'b10 when bus_addr[0] is 1.
- R8: Reset is synchronous and active high. It clears all registers, and bus_addr and lane_en read zero after it.
- R9: A register write in the same cycle as an advance wins, and the advance is dropped. Outputs are registered and show the effect of a clock edge directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 selects word mode, 0 selects byte mode |
| wr_data | input | 8 | Data for all register loads |
| wr_addr_lo | input | 1 | Load running address bits 7:0 |
| wr_addr_hi | input | 1 | Load running address bits 15:8 |
| wr_page | input | 1 | Load page register |
| wr_hipage | input | 1 | Load upper page and turn extension on |
| advance | input | 1 | Step the running address by one transfer |
| bus_addr | output | 32 | Registered physical address |
| lane_en | output | 2 | Registered byte-lane enables |

## Verification
Some properties are checked on every cycle. In word mode, address bit 0 is zero and both lanes are enabled. In byte mode, exactly one lane is enabled and it follows bit 0. A plain advance steps the running address by one. With extension off, the page does not move. With extension on, a byte-mode wrap carries into the page. The extension flag follows the strobes.

Other behaviour can only be shown by the bench's scenarios, which set up particular register values and check the full 32-bit result. These scenarios cover the exact bit placement in each mode and a page bit 0 that is ignored. They cover the carry from the page into the upper page and the write order that leaves extension off. They also cover the reset value and a write that beats an advance in the same cycle.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int LANES = 2;
  localparam logic [LANES-1:0] LANES_BOTH = 2'b11;
  localparam logic [LANES-1:0] LANE_EVEN  = 2'b01;
  localparam logic [LANES-1:0] LANE_ODD   = 2'b10;
endpackage

// File: rtl/dma_page_regs.sv
module dma_page_regs #(
  parameter int DATA_W = 8,
  localparam int ADDR_BYTES = 2,
  localparam int ADDR_W = ADDR_BYTES * DATA_W,
  localparam int PG_W = 2 * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  word_mode,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_BYTES-1:0] wr_addr_byte,
  input  logic                  wr_page,
  input  logic                  wr_hipage,
  input  logic                  advance,
  output logic [ADDR_W-1:0]     addr_d,
  output logic [DATA_W-1:0]     page_d,
  output logic [DATA_W-1:0]     hipage_d,
  output logic [ADDR_W-1:0]     addr_q,
  output logic [DATA_W-1:0]     page_q,
  output logic [DATA_W-1:0]     hipage_q,
  output logic                  ext_q
);
  logic [ADDR_W-1:0] load_mask;
  logic              any_wr;
  logic              ext_d;
  logic              wrap;
  logic [PG_W-1:0]   pg_byte_inc;
  logic [PG_W-2:0]   pg_word_inc;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_mask
    assign load_mask[b*DATA_W +: DATA_W] = {DATA_W{wr_addr_byte[b]}};
  end

  assign any_wr      = (|wr_addr_byte) | wr_page | wr_hipage;
  assign wrap        = &addr_q;
  assign pg_byte_inc = {hipage_q, page_q} + 1'b1;
  assign pg_word_inc = {hipage_q, page_q[DATA_W-1:1]} + 1'b1;

  always_comb begin
    addr_d   = addr_q;
    page_d   = page_q;
    hipage_d = hipage_q;
    ext_d    = ext_q;
    if (any_wr) begin
      addr_d = (addr_q & ~load_mask) | ({ADDR_BYTES{wr_data}} & load_mask);
      if (wr_page)   page_d   = wr_data;
      if (wr_hipage) hipage_d = wr_data;
      ext_d = wr_hipage;
    end else if (advance) begin
      addr_d = addr_q + 1'b1;
      if (wrap && ext_q) begin
        if (word_mode) {hipage_d, page_d[DATA_W-1:1]} = pg_word_inc;
        else           {hipage_d, page_d} = pg_byte_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      page_q   <= '0;
      hipage_q <= '0;
      ext_q    <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      page_q   <= page_d;
      hipage_q <= hipage_d;
      ext_q    <= ext_d;
    end
  end
endmodule

// File: rtl/dma_bus_out.sv
module dma_bus_out
  import dma_addr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int OUT_W = 4 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] page_d,
  input  logic [DATA_W-1:0] hipage_d,
  output logic [OUT_W-1:0]  bus_addr,
  output logic [LANES-1:0]  lane_en
);
  logic [OUT_W-1:0] addr_c;
  logic [LANES-1:0] lane_c;

  always_comb begin
    if (word_mode) begin
      addr_c = {hipage_d, page_d[DATA_W-1:1], addr_d, 1'b0};
      lane_c = LANES_BOTH;
    end else begin
      addr_c = {hipage_d, page_d, addr_d};
      lane_c = addr_d[0] ? LANE_ODD : LANE_EVEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      lane_en  <= '0;
    end else begin
      bus_addr <= addr_c;
      lane_en  <= lane_c;
    end
  end
endmodule

// File: rtl/paged_dma_addr_gen.sv
module paged_dma_addr_gen #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int OUT_W = 4 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr_lo,
  input  logic              wr_addr_hi,
  input  logic              wr_page,
  input  logic              wr_hipage,
  input  logic              advance,
  output logic [OUT_W-1:0]  bus_addr,
  output logic [1:0]        lane_en
);
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] page_d, page_q, hipage_d, hipage_q;
  logic              ext_q;

  dma_page_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .word_mode(word_mode), .wr_data(wr_data),
    .wr_addr_byte({wr_addr_hi, wr_addr_lo}), .wr_page(wr_page),
    .wr_hipage(wr_hipage), .advance(advance),
    .addr_d(addr_d), .page_d(page_d), .hipage_d(hipage_d),
    .addr_q(addr_q), .page_q(page_q), .hipage_q(hipage_q), .ext_q(ext_q)
  );

  dma_bus_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .addr_d(addr_d), .page_d(page_d), .hipage_d(hipage_d),
    .bus_addr(bus_addr), .lane_en(lane_en)
  );
endmodule

// File: rtl/dma_addr_checker.sv
module dma_addr_checker #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int OUT_W = 4 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              word_mode,
  input logic              wr_addr_lo,
  input logic              wr_addr_hi,
  input logic              wr_page,
  input logic              wr_hipage,
  input logic              advance,
  input logic [OUT_W-1:0]  bus_addr,
  input logic [1:0]        lane_en,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] page_q,
  input logic [DATA_W-1:0] hipage_q,
  input logic              ext_q
);
  logic wr_any;
  assign wr_any = wr_addr_lo | wr_addr_hi | wr_page | wr_hipage;

  assert_word_even_R2: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> (bus_addr[0] == 1'b0));

  assert_word_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> (lane_en == 2'b11));

  assert_byte_lane_R7: assert property (@(posedge clk) disable iff (rst)
    !word_mode |=> ($onehot0(lane_en) && lane_en != 2'b00 && lane_en[1] == bus_addr[0]));

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (advance && !wr_any) |=> ((addr_q - $past(addr_q)) == ADDR_W'(1)));

  assert_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !wr_any && !ext_q) |=> ($stable(page_q) && $stable(hipage_q)));

  assert_ext_set_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hipage |=> ext_q);

  assert_ext_clr_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_addr_lo || wr_addr_hi || wr_page) && !wr_hipage) |=> !ext_q);

  assert_byte_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && !wr_any && ext_q && !word_mode && (&addr_q))
    |=> (({hipage_q, page_q} - $past({hipage_q, page_q})) == (2*DATA_W)'(1)));
endmodule

bind paged_dma_addr_gen dma_addr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .word_mode(word_mode), .wr_addr_lo(wr_addr_lo),
  .wr_addr_hi(wr_addr_hi), .wr_page(wr_page), .wr_hipage(wr_hipage),
  .advance(advance), .bus_addr(bus_addr), .lane_en(lane_en),
  .addr_q(addr_q), .page_q(page_q), .hipage_q(hipage_q), .ext_q(ext_q)
);

// File: tb/paged_dma_addr_gen_tb.sv
module paged_dma_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        wr_addr_lo = 1'b0, wr_addr_hi = 1'b0, wr_page = 1'b0, wr_hipage = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  lane_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  paged_dma_addr_gen u_dut (
    .clk(clk), .rst(rst), .word_mode(word_mode), .wr_data(wr_data),
    .wr_addr_lo(wr_addr_lo), .wr_addr_hi(wr_addr_hi), .wr_page(wr_page),
    .wr_hipage(wr_hipage), .advance(advance), .bus_addr(bus_addr), .lane_en(lane_en)
  );

  typedef struct packed {
    logic        wm;
    logic        ext;
    logic [15:0] a;
    logic [7:0]  pg;
    logic [7:0]  hp;
    logic [3:0]  n;
    logic [31:0] exp;
    logic [1:0]  ln;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h1234, 8'h56, 8'h9A, 4'd0, 32'h9A56_1234, 2'b01},
    '{1'b0, 1'b0, 16'hFFFF, 8'h56, 8'h9A, 4'd1, 32'h9A56_0000, 2'b01},
    '{1'b0, 1'b1, 16'hFFFF, 8'h56, 8'h9A, 4'd1, 32'h9A57_0000, 2'b01},
    '{1'b0, 1'b1, 16'hFFFE, 8'hFF, 8'h12, 4'd3, 32'h1300_0001, 2'b10},
    '{1'b1, 1'b0, 16'h1234, 8'h57, 8'h9A, 4'd0, 32'h9A56_2468, 2'b11},
    '{1'b1, 1'b0, 16'hFFFF, 8'h56, 8'h9A, 4'd1, 32'h9A56_0000, 2'b11},
    '{1'b1, 1'b1, 16'hFFFF, 8'h56, 8'h9A, 4'd1, 32'h9A58_0000, 2'b11},
    '{1'b1, 1'b1, 16'hFFFF, 8'hFF, 8'h01, 4'd2, 32'h0200_0002, 2'b11},
    '{1'b0, 1'b0, 16'h00FF, 8'h00, 8'h00, 4'd1, 32'h0000_0100, 2'b01},
    '{1'b0, 1'b1, 16'h1235, 8'h00, 8'h00, 4'd0, 32'h0000_1235, 2'b10}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // sel: 0 addr low, 1 addr high, 2 page, 3 upper page
  task automatic wr(input int sel, input logic [7:0] d, input logic adv = 1'b0);
    wr_data = d;
    wr_addr_lo = (sel == 0); wr_addr_hi = (sel == 1);
    wr_page = (sel == 2); wr_hipage = (sel == 3);
    advance = adv;
    @(posedge clk); @(negedge clk);
    wr_addr_lo = 1'b0; wr_addr_hi = 1'b0; wr_page = 1'b0; wr_hipage = 1'b0;
    advance = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      advance = 1'b1;
      @(posedge clk); @(negedge clk);
      advance = 1'b0;
    end
  endtask

  task automatic load(input logic ext, input logic [15:0] a, input logic [7:0] pg, input logic [7:0] hp);
    if (!ext) wr(3, hp);
    wr(0, a[7:0]);
    wr(1, a[15:8]);
    wr(2, pg);
    if (ext) wr(3, hp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset addr", bus_addr, 32'h0);
    check("R8 reset lanes", {30'd0, lane_en}, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 byte lane after reset", {30'd0, lane_en}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].wm ? (VECS[v].ext ? "R2 R5 word" : "R2 R3 word")
                       : (VECS[v].ext ? "R1 R5 byte" : "R1 R3 R6 byte");
      word_mode = VECS[v].wm;
      load(VECS[v].ext, VECS[v].a, VECS[v].pg, VECS[v].hp);
      step(int'(VECS[v].n));
      check($sformatf("%s vec %0d addr", tag, v), bus_addr, VECS[v].exp);
      check($sformatf("R7 vec %0d lanes", v), {30'd0, lane_en}, {30'd0, VECS[v].ln});
    end

    // R4: a page write after the upper page turns extension off again
    word_mode = 1'b0;
    load(1'b1, 16'hFFFF, 8'h20, 8'h33);
    wr(2, 8'h40);
    step(1);
    check("R4 ext cleared by page write", bus_addr, 32'h3340_0000);

    // R9: write beats advance in the same cycle
    load(1'b0, 16'h0010, 8'h11, 8'h22);
    wr(0, 8'h80, 1'b1);
    check("R9 write wins over advance", bus_addr, 32'h2211_0080);

    // R6 word unit and R2 live mode switch on held registers
    word_mode = 1'b1;
    step(1);
    check("R6 word step", bus_addr, 32'h2210_0102);
    word_mode = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 mode switch", bus_addr, 32'h2211_0081);
    check("R7 odd byte lane", {30'd0, lane_en}, 32'h2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule